// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block decides when and how the internal reset of a small microcontroller is applied. It watches a debounced view of the external active-low reset pin, a one-cycle software reset request, a digital flag that reports whether the reset-delay capacitor is charged, a mode bit that lets the block pull the reset pin low itself, and the sixteen port-0 configuration pins.

An external reset that stays low long enough takes one of two paths. If the capacitor flag is low, the asynchronous path applies the internal reset combinationally and lets go one clock after the pin is released. If the flag is high, the synchronous path holds the reset while the pin is low. After the pin is released it waits a short delay chosen by the clock-source select and then runs a fixed-length sequence. A software request runs the same delay and sequence and never uses the asynchronous path. At the end of each reset the block captures the configuration word and records which kind of reset took place.

Top module: `rst_seq`

## Requirements
- R1: A low on `ext_rst_n` is recognised only after FILT_CYC consecutive low clocks, where FILT_CYC = ceil(FILT_NS / CLK_NS) (default 25 clocks, 500 ns at 20 ns). A low run of FILT_CYC-1 clocks changes neither `sys_rst_n` nor `rst_kind`.
- R2: While a recognised external reset is present and `cap_hi` is low, `sys_rst_n` is low in that same cycle with no register stage. After the pin is released, `sys_rst_n` returns high one clock after recognition clears, with no delay or sequence, and `rst_kind` becomes 1 (asynchronous).
- R3: If `cap_hi` falls while a synchronous external reset is being held, the block changes to the asynchronous path. Release then follows R2 and `rst_kind` becomes 1.
- R4: A recognised external reset with `cap_hi` high holds `sys_rst_n` low while the pin is low. After the pin is released, `sys_rst_n` stays low for the delay and then for SEQ_LEN more clocks (default 1024), and `rst_kind` becomes 2 (synchronous hardware).
- R5: The delay is 3 + `clk_sel` clocks for `clk_sel` values 0 to 5, and 8 clocks for values 6 and 7.
- R6: A `sw_req` pulse while the block is idle holds `sys_rst_n` low for the delay plus SEQ_LEN clocks whatever the level of `cap_hi`. `rst_kind` then becomes 3 (software).
- R7: At the end of an asynchronous or synchronous hardware reset, `cfg_q` takes all sixteen bits of `cfg_pins`.
- R8: At the end of a software reset, `cfg_q[12:8]` takes `cfg_pins[12:8]`, `cfg_q[7:2]` is set to all ones, and `cfg_q[15:13]` and `cfg_q[1:0]` keep their previous values.
- R9: During a software reset `pin_pull` is high exactly when `bidir_en` and `cap_hi` are both high. It is never high during a hardware reset. While `pin_pull` is high, lows on `ext_rst_n` are not counted by the filter.
- R10: A `sw_req` that arrives while a reset is in progress is ignored and does not lengthen the reset.
- R11: After `pwr_rst_n` is released, `sys_rst_n` is high, `pin_pull` is low, `cfg_q` is 0 and `rst_kind` is 0 (none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Power-on reset of the block itself, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin level, active low |
| sw_req | input | 1 | Software reset request, one-cycle strobe |
| cap_hi | input | 1 | Reset-delay capacitor charged flag |
| bidir_en | input | 1 | Lets the block drive the reset pin during a software reset |
| clk_sel | input | 3 | Clock-source select that sets the delay length |
| cfg_pins | input | 16 | Port-0 configuration pin levels |
| sys_rst_n | output | 1 | Internal reset, active low |
| pin_pull | output | 1 | Open-drain pull-down enable for the reset pin |
| cfg_q | output | 16 | Latched configuration word |
| rst_kind | output | 2 | Last reset type: 0 none, 1 asynchronous, 2 synchronous hardware, 3 software |

## Verification
The bench checks the filter at FILT_CYC-1 and FILT_CYC low clocks. A filter that is off by one would either start a reset on a glitch or drop the shortest valid pulse and lose a clock of hold time. It checks that the asynchronous path drops `sys_rst_n` in the clock where recognition occurs. A registered path would show the reset one clock late. It drops `cap_hi` during a held synchronous reset and checks that no full sequence follows the release, which would show a design that stays on the synchronous path. It also checks the partial configuration capture after a software reset, the sequence length for every delay select, a second request during a sequence, and a pin low while the block is pulling the pin. Errors there show up as wrong bits in `cfg_q`, a longer reset, or a software reset that turns into a hardware reset.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int CFG_W = 16;

  // Software reset: bits sampled from the pins, bits forced high, bits kept
  localparam logic [CFG_W-1:0] SW_SAMPLE = 16'h1F00;
  localparam logic [CFG_W-1:0] SW_ONES   = 16'h00FC;
  localparam logic [CFG_W-1:0] SW_KEEP   = 16'hE003;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_ASYNC = 3'd2,
    ST_DLY   = 3'd3,
    ST_SEQ   = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_ASYNC = 2'd1,
    K_HW    = 2'd2,
    K_SW    = 2'd3
  } rst_kind_e;
endpackage

// File: rtl/rst_seq_filt.sv
module rst_seq_filt #(
  parameter int FILT_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  output logic hit
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin_low)
      cnt_d = '0;
    else if (cnt_q != FW'(FILT_CYC))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == FW'(FILT_CYC));

  // R1: recognition needs the pin to have been low in the previous clock
  p_filter_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(pin_low));
endmodule

// File: rtl/rst_seq_dly.sv
module rst_seq_dly #(
  parameter int SEL_W = 3,
  parameter int DLY_MIN = 3,
  parameter int DLY_MAX = 8,
  parameter int DW = 4
) (
  input  logic [SEL_W-1:0] sel,
  output logic [DW-1:0]    dly_len
);
  localparam int SEL_TOP = DLY_MAX - DLY_MIN;

  always_comb begin
    if (int'(sel) > SEL_TOP) dly_len = DW'(DLY_MAX);
    else                     dly_len = DW'(DLY_MIN) + DW'(sel);
  end
endmodule

// File: rtl/rst_seq_cfg.sv
module rst_seq_cfg
  import rst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  rst_kind_e        fin_kind,
  input  logic [CFG_W-1:0] pins,
  output logic [CFG_W-1:0] cfg_q,
  output logic [1:0]       kind_q
);
  logic [CFG_W-1:0] cfg_d;
  logic [1:0]       kind_d;

  always_comb begin
    cfg_d  = cfg_q;
    kind_d = kind_q;
    if (fin) begin
      kind_d = fin_kind;
      if (fin_kind == K_SW)
        cfg_d = (cfg_q & SW_KEEP) | (pins & SW_SAMPLE) | SW_ONES;
      else
        cfg_d = pins;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      kind_q <= K_NONE;
    end else if (fin) begin
      cfg_q  <= cfg_d;
      kind_q <= kind_d;
    end
  end

  // R7: hardware reset end captures every pin
  p_hw_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_kind != K_SW) |=> cfg_q == $past(pins));

  // R8: software reset end forces the middle field high and keeps the outer bits
  p_sw_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fin_kind == K_SW) |=> (cfg_q[7:2] == 6'h3F)
      && (cfg_q[1:0] == $past(cfg_q[1:0])) && (cfg_q[15:13] == $past(cfg_q[15:13])));
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int CLK_NS  = 20,
  parameter int FILT_NS = 500,
  parameter int SEQ_LEN = 1024
) (
  input  logic        clk,
  input  logic        pwr_rst_n,
  input  logic        ext_rst_n,
  input  logic        sw_req,
  input  logic        cap_hi,
  input  logic        bidir_en,
  input  logic [2:0]  clk_sel,
  input  logic [15:0] cfg_pins,
  output logic        sys_rst_n,
  output logic        pin_pull,
  output logic [15:0] cfg_q,
  output logic [1:0]  rst_kind
);
  localparam int FILT_CYC = (FILT_NS + CLK_NS - 1) / CLK_NS;
  localparam int DW = 4;
  localparam int CW = $clog2(SEQ_LEN + 8) + 1;

  seq_st_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic      swf_q, swf_d;
  logic      ext_hit, pin_low, fin, async_now;
  rst_kind_e fin_kind;
  logic [DW-1:0] dly_len;

  // Lows caused by the block's own pull-down are not counted
  assign pin_low = !ext_rst_n && !pin_pull;

  rst_seq_filt #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk     (clk),
    .rst_n   (pwr_rst_n),
    .pin_low (pin_low),
    .hit     (ext_hit)
  );

  rst_seq_dly #(.SEL_W(3), .DLY_MIN(3), .DLY_MAX(8), .DW(DW)) u_dly (
    .sel     (clk_sel),
    .dly_len (dly_len)
  );

  // Next-state process
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    swf_d    = swf_q;
    fin      = 1'b0;
    fin_kind = K_HW;
    if (ext_hit) begin
      swf_d = 1'b0;
      if (!cap_hi || st_q == ST_ASYNC) st_d = ST_ASYNC;
      else                             st_d = ST_HOLD;
    end else begin
      case (st_q)
        ST_IDLE: if (sw_req) begin
          st_d  = ST_DLY;
          cnt_d = CW'(dly_len) - 1'b1;
          swf_d = 1'b1;
        end
        ST_HOLD: begin
          st_d  = ST_DLY;
          cnt_d = CW'(dly_len) - 1'b1;
        end
        ST_ASYNC: begin
          st_d     = ST_IDLE;
          fin      = 1'b1;
          fin_kind = K_ASYNC;
        end
        ST_DLY: begin
          if (cnt_q == '0) begin
            st_d  = ST_SEQ;
            cnt_d = CW'(SEQ_LEN - 1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_SEQ: begin
          if (cnt_q == '0) begin
            st_d     = ST_IDLE;
            fin      = 1'b1;
            fin_kind = swf_q ? K_SW : K_HW;
            swf_d    = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      swf_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      swf_q <= swf_d;
    end
  end

  assign async_now = ext_hit && !cap_hi;
  assign sys_rst_n = (st_q == ST_IDLE) && !async_now;
  assign pin_pull  = swf_q && bidir_en && cap_hi
                     && (st_q == ST_DLY || st_q == ST_SEQ);

  rst_seq_cfg u_cfg (
    .clk      (clk),
    .rst_n    (pwr_rst_n),
    .fin      (fin),
    .fin_kind (fin_kind),
    .pins     (cfg_pins),
    .cfg_q    (cfg_q),
    .kind_q   (rst_kind)
  );

  // R2: asynchronous entry shows on the output in the same cycle
  p_async_now_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (ext_hit && !cap_hi) |-> !sys_rst_n);

  // R3: once on the asynchronous path, a recognised reset keeps it there
  p_async_stay_r3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (st_q == ST_ASYNC && ext_hit) |=> st_q == ST_ASYNC);

  // R9: the pull-down only acts inside a running reset
  p_pull_in_reset_r9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    pin_pull |-> !sys_rst_n);

  // R10: a request during the sequence does not restart it
  p_sw_ignored_r10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (st_q == ST_SEQ && cnt_q != '0 && sw_req && !ext_hit) |=> st_q == ST_SEQ);
endmodule

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam int CLK_PER = 20;
  localparam int SEQ = 64;
  localparam int FILT = 25;

  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic ext_rst_n = 1'b1;
  logic sw_req = 1'b0;
  logic cap_hi = 1'b1;
  logic bidir_en = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [15:0] cfg_pins = 16'h0000;
  logic sys_rst_n, pin_pull;
  logic [15:0] cfg_q;
  logic [1:0] rst_kind;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [15:0] m_cfg = 16'h0000;

  always #(CLK_PER/2) clk = ~clk;

  rst_seq #(.CLK_NS(20), .FILT_NS(500), .SEQ_LEN(SEQ)) uut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .ext_rst_n(ext_rst_n), .sw_req(sw_req),
    .cap_hi(cap_hi), .bidir_en(bidir_en), .clk_sel(clk_sel), .cfg_pins(cfg_pins),
    .sys_rst_n(sys_rst_n), .pin_pull(pin_pull), .cfg_q(cfg_q), .rst_kind(rst_kind)
  );

  // {sel[2:0], bidir, cap, pins[15:0], expected pull}
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b1, 16'hA5C3, 1'b1},
    {3'd5, 1'b1, 1'b0, 16'h1234, 1'b0},
    {3'd6, 1'b0, 1'b1, 16'hFFFF, 1'b0},
    {3'd2, 1'b1, 1'b1, 16'h0000, 1'b1},
    {3'd7, 1'b0, 1'b0, 16'h5A5A, 1'b0},
    {3'd3, 1'b1, 1'b1, 16'hE0FF, 1'b1}
  };

  function automatic int dly_of(input logic [2:0] s);
    return (s > 3'd5) ? 8 : 3 + int'(s);
  endfunction

  function automatic logic [15:0] sw_model(input logic [15:0] old, input logic [15:0] p);
    return (old & 16'hE003) | (p & 16'h1F00) | 16'h00FC;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Software reset; optional second request at step again_at, optional pin low window
  task automatic run_sw(input int again_at, input int ext_from, input int ext_len,
                        output int len, output logic pull_seen);
    @(negedge clk) sw_req = 1'b1;
    @(negedge clk) sw_req = 1'b0;
    pull_seen = pin_pull;
    len = 0;
    while (!sys_rst_n && len < 5000) begin
      len++;
      if (len == again_at) sw_req = 1'b1;
      else sw_req = 1'b0;
      if (len == ext_from) ext_rst_n = 1'b0;
      if (len == ext_from + ext_len) ext_rst_n = 1'b1;
      @(negedge clk);
    end
    sw_req = 1'b0;
    ext_rst_n = 1'b1;
  endtask

  // External low for n clocks; cap dropped after sample fall_at (0: never)
  task automatic run_hw(input int n, input int fall_at, output int len,
                        output logic s24, output logic s25, output logic pull_mid);
    len = 0; s24 = 1'b1; s25 = 1'b1; pull_mid = 1'b0;
    ext_rst_n = 1'b0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (!sys_rst_n) len++;
      if (i == 24) s24 = sys_rst_n;
      if (i == 25) s25 = sys_rst_n;
      if (pin_pull) pull_mid = 1'b1;
      if (i == fall_at) cap_hi = 1'b0;
    end
    ext_rst_n = 1'b1;
    @(negedge clk);
    while (!sys_rst_n && len < 5000) begin
      len++;
      if (pin_pull) pull_mid = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len;
    logic pl, s24, s25, pm;
    logic [2:0] sel;

    repeat (3) @(negedge clk);
    // R11: values while and after power reset
    chk("R11 sys_rst_n", sys_rst_n, 1);
    pwr_rst_n = 1'b1;
    @(negedge clk);
    chk("R11 sys_rst_n", sys_rst_n, 1);
    chk("R11 pin_pull", pin_pull, 0);
    chk("R11 cfg_q", cfg_q, 0);
    chk("R11 rst_kind", rst_kind, 0);

    // Vector table of software resets: R5 R6 R8 R9
    for (int v = 0; v < NV; v++) begin
      sel = VEC[v][21:19];
      clk_sel = sel; bidir_en = VEC[v][18]; cap_hi = VEC[v][17];
      cfg_pins = VEC[v][16:1];
      run_sw(0, 0, 0, len, pl);
      m_cfg = sw_model(m_cfg, cfg_pins);
      chk("R5 R6 sw length", len, dly_of(sel) + SEQ);
      chk("R9 pull", pl, VEC[v][0]);
      chk("R8 cfg", cfg_q, m_cfg);
      chk("R6 kind", rst_kind, 3);
    end
    cap_hi = 1'b1; bidir_en = 1'b0; clk_sel = 3'd0;

    // R1: one clock short of the filter does nothing
    cfg_pins = 16'h7777;
    run_hw(FILT - 1, 0, len, s24, s25, pm);
    chk("R1 short pulse length", len, 0);
    chk("R1 short pulse kind", rst_kind, 3);
    chk("R1 short pulse cfg", cfg_q, m_cfg);

    // R1 R4: exactly the filter length starts a synchronous reset
    cfg_pins = 16'h8421;
    run_hw(FILT, 0, len, s24, s25, pm);
    chk("R1 R4 min pulse length", len, 1 + 3 + SEQ);
    chk("R4 sync not yet low at recognition", s25, 1);
    chk("R4 kind", rst_kind, 2);
    chk("R7 cfg all bits", cfg_q, 16'h8421);
    m_cfg = 16'h8421;

    // R4 R9: longer hold, no pull during hardware reset
    bidir_en = 1'b1; clk_sel = 3'd4; cfg_pins = 16'h3C3C;
    run_hw(40, 0, len, s24, s25, pm);
    chk("R4 R5 long hold length", len, 16 + 7 + SEQ);
    chk("R9 no pull in hw reset", pm, 0);
    chk("R7 cfg", cfg_q, 16'h3C3C);
    m_cfg = 16'h3C3C;
    clk_sel = 3'd0;

    // R2: asynchronous path, same-cycle assertion
    cap_hi = 1'b0; cfg_pins = 16'hBEEF;
    run_hw(40, 0, len, s24, s25, pm);
    chk("R2 not before recognition", s24, 1);
    chk("R2 low at recognition", s25, 0);
    chk("R2 async length", len, 40 - 23);
    chk("R2 kind", rst_kind, 1);
    chk("R7 async cfg", cfg_q, 16'hBEEF);
    m_cfg = 16'hBEEF;
    cap_hi = 1'b1;
    @(negedge clk);

    // R3: capacitor flag falls during a held synchronous reset
    cfg_pins = 16'h0F0F;
    run_hw(40, 30, len, s24, s25, pm);
    chk("R3 switch length", len, 40 - 24);
    chk("R3 kind", rst_kind, 1);
    chk("R3 cfg", cfg_q, 16'h0F0F);
    m_cfg = 16'h0F0F;
    cap_hi = 1'b1;
    @(negedge clk);

    // R10: second request during the sequence is ignored
    clk_sel = 3'd1; bidir_en = 1'b0; cfg_pins = 16'hFFFF;
    run_sw(20, 0, 0, len, pl);
    m_cfg = sw_model(m_cfg, cfg_pins);
    chk("R10 length unchanged", len, 4 + SEQ);
    @(negedge clk);
    chk("R10 no restart", sys_rst_n, 1);
    chk("R10 cfg", cfg_q, m_cfg);

    // R9: pin low while the block pulls it is not counted
    bidir_en = 1'b1; cap_hi = 1'b1; clk_sel = 3'd0; cfg_pins = 16'h0100;
    run_sw(0, 5, 30, len, pl);
    m_cfg = sw_model(m_cfg, cfg_pins);
    chk("R9 pull active", pl, 1);
    chk("R9 own pull ignored length", len, 3 + SEQ);
    chk("R9 own pull ignored kind", rst_kind, 3);
    chk("R9 cfg", cfg_q, m_cfg);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule